// File: doc/BRIEF.md
# Serial DAC-Code Slave with Address-Borne LSB

This block is a two-wire serial slave that owns one 8-bit DAC code register. It watches a synchronised copy of the clock and data lines and recognises START and STOP conditions. It shifts bytes in on rising clock edges and pulls the data line low to acknowledge or to return read data. The register contents drive an analog DAC directly.

The first byte of every transfer carries a 6-bit device identifier in its top bits. The next bit is not part of the address: it is bit 0 of the code being written. The last bit selects read (1) or write (0). Because of this, the slave answers to two bus addresses.

In a write, a second byte supplies the upper seven code bits and a mode bit. The write-protect input and that mode bit together decide what the transfer does: it is acknowledged with no effect, it loads the register, or it sends a one-cycle request to an external non-volatile store sequencer, which then saves the current code.

Top module: `vd_dac_slave`

## Requirements
- R1: A first byte whose bits [7:2] equal 6'b100111 is acknowledged by driving the data line low during the ninth clock. Bit 1 may be either 0 or 1.
- R2: A first byte whose bits [7:2] differ from 6'b100111 is not acknowledged. Later bytes are then neither acknowledged nor acted on until the next START.
- R3: With write-protect high, a write whose second byte has bit 0 = 1 loads the register with {second byte [7:1], first byte bit 1}. The load takes effect at the end of the second byte's acknowledge clock.
- R4: With write-protect high, a write whose second byte has bit 0 = 0 raises the store request for exactly one clock cycle and leaves the register unchanged.
- R5: With write-protect low, a write is still acknowledged in both bytes, but the register does not change and no store request is issued, whatever bit 0 of the second byte is.
- R6: A read (first byte bit 0 = 1) returns the full 8-bit register, MSB first, in the byte after the address acknowledge. This holds at either write-protect level.
- R7: During a read, a master ACK makes the slave send the register again. A master NACK makes the slave release the data line until the next START.
- R8: A START or STOP seen in the middle of a byte abandons the transfer and leaves the register unchanged. A STOP always releases the data line.
- R9: After reset the register holds 0, the data line is released and no store request is raised.
- R10: A store request is never asserted on two consecutive clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired-AND result) |
| wp_i | input | 1 | Write-protect level; high permits register load and store requests |
| sda_pull_o | output | 1 | When 1, the pad pulls the data line low |
| dac_code_o | output | 8 | Current DAC code register |
| prog_req_o | output | 1 | One-cycle request to the store sequencer |

## Verification
The decode is exercised at both write-protect levels and both mode-bit values. This separates register loads from store requests and from acknowledge-only writes. Codes with bit 0 clear and set, together with the extremes 0x00 and 0xFF, show that the LSB really comes from the address byte. Reads with a NACK and with a chained ACK show both read endings. Foreign addresses and transfers broken by a mid-byte START or STOP must leave the register as the reference model predicts. That model is compared with the register output on every clock.

// File: rtl/vd_pkg.sv
package vd_pkg;
  localparam int unsigned CODE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK1,
    ST_WR,
    ST_ACK2,
    ST_RD,
    ST_MACK,
    ST_SKIP
  } bus_st_e;
endpackage

// File: rtl/vd_line_mon.sv
module vd_line_mon #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_p, sda_p;
  logic scl_n, sda_n;

  assign scl_n = scl_sh[STAGES-1];
  assign sda_n = sda_sh[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_p  <= scl_n;
      sda_p  <= sda_n;
    end
  end

  assign sda_o      = sda_n;
  assign scl_rise_o = scl_n & ~scl_p;
  assign scl_fall_o = ~scl_n & scl_p;
  assign start_o    = scl_n & scl_p & sda_p & ~sda_n;
  assign stop_o     = scl_n & scl_p & ~sda_p & sda_n;
endmodule

// File: rtl/vd_commit.sv
module vd_commit #(
  parameter int unsigned W = vd_pkg::CODE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         commit_i,
  input  logic         wp_i,
  input  logic         load_mode_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] code_o,
  output logic         prog_o
);
  logic [W-1:0] code_q, code_d;
  logic         prog_q, prog_d;

  always_comb begin
    code_d = code_q;
    prog_d = 1'b0;
    if (commit_i && wp_i) begin
      if (load_mode_i) code_d = wdata_i;
      else             prog_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      prog_q <= 1'b0;
    end else begin
      code_q <= code_d;
      prog_q <= prog_d;
    end
  end

  assign code_o = code_q;
  assign prog_o = prog_q;

  a_r5_protected_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && !wp_i) |=> ($stable(code_q) && !prog_q));
  a_r4_store_keeps_code: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && wp_i && !load_mode_i) |=> ($stable(code_q) && prog_q));
  a_r10_store_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    prog_q |=> !prog_q);
endmodule

// File: rtl/vd_dac_slave.sv
module vd_dac_slave #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [5:0]  DEV_ID      = 6'b100111
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       wp_i,
  output logic       sda_pull_o,
  output logic [7:0] dac_code_o,
  output logic       prog_req_o
);
  import vd_pkg::*;

  localparam int unsigned W     = CODE_W;
  localparam int unsigned CNT_W = $clog2(W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(W);

  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  logic sda_s, rise, fall, start_ev, stop_ev;

  vd_line_mon #(.STAGES(SYNC_STAGES)) u_mon (
    .clk        (clk),
    .rst_n      (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (rise),
    .scl_fall_o (fall),
    .start_o    (start_ev),
    .stop_o     (stop_ev)
  );

  bus_st_e          st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [W-1:0]     sh_q, sh_d, tx_q, tx_d;
  logic             y_q, y_d, rw_q, rw_d, mack_q, mack_d;
  logic             pull_q, pull_d;
  logic             commit;
  logic [W-1:0]     code;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    tx_d   = tx_q;
    y_d    = y_q;
    rw_d   = rw_q;
    mack_d = mack_q;
    pull_d = pull_q;
    commit = 1'b0;
    if (stop_ev) begin
      st_d   = ST_IDLE;
      pull_d = 1'b0;
    end else if (start_ev) begin
      st_d   = ST_ADDR;
      cnt_d  = '0;
      pull_d = 1'b0;
    end else begin
      case (st_q)
        ST_ADDR, ST_WR: begin
          if (rise) begin
            sh_d  = {sh_q[W-2:0], sda_s};
            cnt_d = cnt_q + 1'b1;
          end
          if (fall && cnt_q == FULL) begin
            if (st_q == ST_WR) begin
              st_d   = ST_ACK2;
              pull_d = 1'b1;
            end else if (sh_q[W-1:2] == DEV_ID) begin
              y_d    = sh_q[1];
              rw_d   = sh_q[0];
              st_d   = ST_ACK1;
              pull_d = 1'b1;
            end else begin
              st_d = ST_SKIP;
            end
          end
        end
        ST_ACK1: begin
          if (fall) begin
            cnt_d = '0;
            if (rw_q) begin
              st_d   = ST_RD;
              tx_d   = code;
              pull_d = ~code[W-1];
            end else begin
              st_d   = ST_WR;
              pull_d = 1'b0;
            end
          end
        end
        ST_ACK2: begin
          if (fall) begin
            commit = 1'b1;
            pull_d = 1'b0;
            st_d   = ST_SKIP;
          end
        end
        ST_RD: begin
          if (rise) cnt_d = cnt_q + 1'b1;
          if (fall) begin
            if (cnt_q == FULL) begin
              st_d   = ST_MACK;
              pull_d = 1'b0;
            end else begin
              tx_d   = {tx_q[W-2:0], 1'b0};
              pull_d = ~tx_q[W-2];
            end
          end
        end
        ST_MACK: begin
          if (rise) mack_d = ~sda_s;
          if (fall) begin
            if (mack_q) begin
              st_d   = ST_RD;
              cnt_d  = '0;
              tx_d   = code;
              pull_d = ~code[W-1];
            end else begin
              st_d = ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      sh_q   <= '0;
      tx_q   <= '0;
      y_q    <= 1'b0;
      rw_q   <= 1'b0;
      mack_q <= 1'b0;
      pull_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      tx_q   <= tx_d;
      y_q    <= y_d;
      rw_q   <= rw_d;
      mack_q <= mack_d;
      pull_q <= pull_d;
    end
  end

  vd_commit #(.W(W)) u_commit (
    .clk         (clk),
    .rst_n       (rst_ni),
    .commit_i    (commit),
    .wp_i        (wp_i),
    .load_mode_i (sh_q[0]),
    .wdata_i     ({sh_q[W-1:1], y_q}),
    .code_o      (code),
    .prog_o      (prog_req_o)
  );

  assign dac_code_o = code;
  assign sda_pull_o = pull_q;

  a_r1_ack_needs_id: assert property (@(posedge clk) disable iff (!rst_ni)
    ($rose(pull_q) && st_q == ST_ACK1) |-> (sh_q[W-1:2] == DEV_ID));
  a_r8_stop_releases: assert property (@(posedge clk) disable iff (!rst_ni)
    stop_ev |=> (!pull_q && st_q == ST_IDLE));
  a_r2_skip_is_quiet: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == ST_SKIP && $past(st_q) == ST_SKIP) |-> !pull_q);
  a_r6_first_bit_is_msb: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == ST_RD && cnt_q == '0) |-> (pull_q == ~code[W-1]));
endmodule

// File: tb/sim_vd_dac_slave.sv
module sim_vd_dac_slave;
  localparam int Q = 10;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, m_scl, m_sda, wp;
  logic       sda_pull, prog_req;
  logic [7:0] dac_code;
  wire        sda_line = m_sda & ~sda_pull;

  vd_dac_slave u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (m_scl),
    .sda_i      (sda_line),
    .wp_i       (wp),
    .sda_pull_o (sda_pull),
    .dac_code_o (dac_code),
    .prog_req_o (prog_req)
  );

  int tests = 0, fails = 0;
  int clk_tests = 0, clk_fails = 0;
  int seen_prog = 0, exp_prog = 0;
  int run_cycles = 0;
  logic [7:0] exp_code = 8'h00;
  bit chk_en = 1'b0;
  bit done = 1'b0;

  // reference model comparison of the register on every clock (R3, R5, R8)
  always @(negedge clk) begin
    run_cycles <= run_cycles + 1;
    if (chk_en) begin
      clk_tests <= clk_tests + 1;
      if (dac_code !== exp_code) begin
        clk_fails <= clk_fails + 1;
        if (clk_fails < 4)
          $display("FAIL R3 per-clock code: act %02h exp %02h", dac_code, exp_code);
      end
    end
  end

  always @(posedge clk) if (rst_n && prog_req) seen_prog <= seen_prog + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act %0h exp %0h", tag, act, exp);
    end
  endtask

  task automatic tk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    m_sda = 1'b1; tk(Q);
    m_scl = 1'b1; tk(Q);
    m_sda = 1'b0; tk(Q);
    m_scl = 1'b0; tk(Q);
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; tk(Q);
    m_scl = 1'b1; tk(Q);
    m_sda = 1'b1; tk(Q);
  endtask

  task automatic put_bit(input bit b);
    m_sda = b; tk(Q);
    m_scl = 1'b1; tk(Q);
    m_scl = 1'b0; tk(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    m_sda = 1'b1; tk(Q);
    m_scl = 1'b1; tk(Q - 1);
    acked = !sda_line;
    tk(1);
    m_scl = 1'b0; tk(Q);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tk(Q);
      m_scl = 1'b1; tk(Q / 2);
      b[i] = sda_line;
      tk(Q - Q / 2);
      m_scl = 1'b0;
    end
    tk(Q);
    m_sda = !give_ack; tk(Q);
    m_scl = 1'b1; tk(Q);
    m_scl = 1'b0; tk(Q);
    m_sda = 1'b1;
  endtask

  // write: address {100111, code[0], 0}, data {code[7:1], mode}
  task automatic do_write(input logic [7:0] code, input bit mode, input bit wp_lvl,
                          output bit a1, output bit a2);
    wp = wp_lvl;
    bus_start;
    send_byte({6'b100111, code[0], 1'b0}, a1);
    chk_en = 1'b0;
    send_byte({code[7:1], mode}, a2);
    if (wp_lvl && mode) exp_code = code;
    if (wp_lvl && !mode) exp_prog++;
    chk_en = 1'b1;
    bus_stop;
    tk(Q);
  endtask

  task automatic do_read(input bit y, input int nbytes, output bit a1,
                         output logic [7:0] last, output logic [7:0] first);
    bus_start;
    send_byte({6'b100111, y, 1'b1}, a1);
    for (int k = 0; k < nbytes; k++) begin
      recv_byte(k != nbytes - 1, last);
      if (k == 0) first = last;
    end
    bus_stop;
    tk(Q);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      $display("FAIL watchdog: act timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", tests + clk_tests + 1, fails + clk_fails + 1);
      $finish;
    end
  end

  initial begin
    bit a1, a2;
    logic [7:0] rd, rd0;
    rst_n = 1'b0; m_scl = 1'b1; m_sda = 1'b1; wp = 1'b0;
    tk(8);
    rst_n = 1'b1;
    tk(8);

    // R9 reset state
    chk("R9 code after reset", dac_code, 8'h00);
    chk("R9 data line released", sda_pull, 1'b0);
    chk("R9 no store request", seen_prog, 0);
    chk_en = 1'b1;

    // R1, R3 write with odd code (address bit1 = 1)
    do_write(8'h5B, 1'b1, 1'b1, a1, a2);
    chk("R1 address ack y=1", a1, 1'b1);
    chk("R3 data ack", a2, 1'b1);
    chk("R3 code loaded 5B", dac_code, 8'h5B);

    // R6, R7 read with NACK
    do_read(1'b0, 1, a1, rd, rd0);
    chk("R1 read address ack", a1, 1'b1);
    chk("R6 read value", rd, 8'h5B);
    chk("R7 released after NACK", sda_pull, 1'b0);

    // R1, R3 even code
    do_write(8'hC2, 1'b1, 1'b1, a1, a2);
    chk("R1 address ack y=0", a1, 1'b1);
    chk("R3 code loaded C2", dac_code, 8'hC2);

    // R5 protected writes in both modes
    do_write(8'h11, 1'b1, 1'b0, a1, a2);
    chk("R5 ack addr protected", a1, 1'b1);
    chk("R5 ack data protected", a2, 1'b1);
    chk("R5 code held", dac_code, 8'hC2);
    do_write(8'h33, 1'b0, 1'b0, a1, a2);
    chk("R5 no store when protected", seen_prog, exp_prog);
    chk("R5 code held mode0", dac_code, 8'hC2);

    // R4 store request
    do_write(8'h77, 1'b0, 1'b1, a1, a2);
    chk("R4 one store request", seen_prog, exp_prog);
    chk("R4 code unchanged", dac_code, 8'hC2);

    // R6 read at wp low, R7 chained read with ACK
    wp = 1'b0;
    do_read(1'b1, 2, a1, rd, rd0);
    chk("R6 read wp low first", rd0, 8'hC2);
    chk("R7 repeated byte after ACK", rd, 8'hC2);

    // R2 foreign address then data byte ignored
    wp = 1'b1;
    bus_start;
    send_byte(8'h90, a1);
    chk("R2 foreign address not acked", a1, 1'b0);
    send_byte(8'hFF, a2);
    chk("R2 following byte not acked", a2, 1'b0);
    bus_stop;
    chk("R2 code unchanged", dac_code, 8'hC2);

    // R8 repeated START mid data byte
    bus_start;
    send_byte(8'h9C, a1);
    for (int i = 0; i < 4; i++) put_bit(1'b1);
    bus_start;
    chk("R8 released after restart", sda_pull, 1'b0);
    bus_stop;
    chk("R8 code unchanged restart", dac_code, 8'hC2);

    // R8 STOP mid data byte
    bus_start;
    send_byte(8'h9E, a1);
    for (int i = 0; i < 3; i++) put_bit(1'b0);
    bus_stop;
    chk("R8 released after stop", sda_pull, 1'b0);
    chk("R8 code unchanged stop", dac_code, 8'hC2);

    // R3 extremes, R6 readback
    do_write(8'hFF, 1'b1, 1'b1, a1, a2);
    chk("R3 code FF", dac_code, 8'hFF);
    do_write(8'h00, 1'b1, 1'b1, a1, a2);
    chk("R3 code 00", dac_code, 8'h00);
    do_write(8'h81, 1'b1, 1'b1, a1, a2);
    do_read(1'b0, 1, a1, rd, rd0);
    chk("R6 read 81", rd, 8'h81);
    chk("R10 total store requests", seen_prog, exp_prog);

    done = 1'b1;
    tk(2);
    $display("[TB] %0d tests run, %0d failed", tests + clk_tests, fails + clk_fails);
    $finish;
  end
endmodule